// File: doc/BRIEF.md
# CPU Hot-Plug Register Controller

This block keeps track of a set of hot-pluggable processor slots and exposes them to host software through a small register window. External logic reports that a CPU has arrived or that its removal is requested. For each slot the block records whether the CPU is enabled, whether an insert event awaits acknowledgement and whether a remove event awaits acknowledgement. Any new event sets a general-purpose event status bit, which can drive an interrupt line when enabled.

After reset the window runs in a legacy mode in which only a read-only presence bitmap is visible. Writing a full zero word to its first location moves the block for good into the indirect interface. In that interface software writes a slot selector, reads a per-slot status byte, writes a per-slot control byte to acknowledge events or request ejection, and issues commands: a round-robin search for the next slot with a pending event, or loads of two report words that are handed to the outside with a one-cycle notification. A controller state machine has three states: `ST_LEGACY` (presence bitmap only), `ST_IDLE` (indirect interface live) and `ST_SCAN` (event search in progress, one slot examined per cycle). Transitions: `ST_LEGACY` to `ST_IDLE` on the zero-word switch write; `ST_IDLE` to `ST_SCAN` on a command write of value 0; `ST_SCAN` to `ST_IDLE` when a slot with a pending event is found or after every slot has been examined.

The access port is a single-cycle byte-enabled port: `acc_addr[3:2]` picks a 32-bit word, `acc_be` the byte lanes, writes act on the clock edge, and `acc_rdata` is a combinational function of the address and the current state.

Top module: `hotplug_regs`

## Requirements
- R1: After reset the block is in legacy mode with all slot flags clear, GPE status and enable clear and `irq` low. In legacy mode a read of word 0 returns the presence bitmap (bit i is 1 when slot i is enabled), words 1 and 2 read 0, and a write to word 0 of any value other than 0x00000000 with all four lanes changes nothing.
- R2: A write of 0x00000000 to word 0 with all four lanes in legacy mode switches to the indirect interface; the switch is permanent, and afterwards a full write to word 0 loads the selector and word 0 reads 0.
- R3: A hot-add pulse on `plug_valid` for slot s < NSLOT sets the enabled and insert flags of s. The status byte (word 1, lane 0) of the selected slot reads bit 0 enabled, bit 1 insert pending, bit 2 remove pending, bits 7:3 zero.
- R4: An unplug request on `unplug_valid` sets the remove flag of an enabled slot and is ignored for a slot that is not enabled.
- R5: A control write (word 1, lane 0) clears the selected slot's insert flag when bit 1 is set and its remove flag when bit 2 is set; bit 0 and bits 7:4 have no effect.
- R6: A control write with bit 3 set raises `eject_pulse` for exactly the cycle after the write with `eject_slot` equal to the selected slot; an `eject_done_valid` pulse clears that slot's enabled and remove flags.
- R7: While the selector is NSLOT or larger, the status byte reads 0 and control writes change no flag and raise no eject pulse.
- R8: A command write (word 1, lane 1) of 0 searches slots starting after the selector and wrapping around (from slot 0 if the selector is out of range), moving the selector to the first slot with an insert or remove flag set; if none is found the selector keeps its value. The search ends within NSLOT cycles, after which word 2 reads the selector while the command is 0.
- R9: Under command 1 a full write to word 2 loads `report_event`; under command 2 it loads `report_status` and raises `report_notify` for one cycle.
- R10: Under any command other than 0, a read of word 2 returns 0xFFFFFFFF; under a command of 3 or more, a write to word 2 changes neither report word.
- R11: Word 3 lane 0 bit 2 is the GPE status bit, set by any accepted hot-add or unplug request and cleared by writing 1 to it; word 3 lane 1 bit 2 is the GPE enable. `irq` is high exactly when both are set, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 4 | Byte address within the window (bits 3:2 used) |
| acc_be | input | 4 | Byte-lane enables |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_addr` |
| plug_valid | input | 1 | Hot-add pulse |
| plug_slot | input | SW | Slot of the hot-add |
| unplug_valid | input | 1 | Removal request pulse |
| unplug_slot | input | SW | Slot of the removal request |
| eject_done_valid | input | 1 | Ejection completed pulse |
| eject_done_slot | input | SW | Slot whose ejection completed |
| eject_pulse | output | 1 | One-cycle ejection request |
| eject_slot | output | SW | Slot to eject |
| report_event | output | 32 | Stored report event word |
| report_status | output | 32 | Stored report status word |
| report_notify | output | 1 | One-cycle pulse when the report status is loaded |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with NSLOT = 6, a count that is not a power of two, so the 3-bit selector can name slots 6 and 7 that do not exist and the out-of-range status and control paths of R7 are reached, as is a search that begins from an out-of-range selector. Six slots also keep the wrap-around of the search within a few cycles, so directed searches that wrap past the last slot and searches that find nothing are cheap to set up next to a long random run of hot-add, unplug, select and acknowledge operations checked against a bench model.

// File: rtl/hp_pkg.sv
package hp_pkg;
    typedef enum logic [1:0] {
        ST_LEGACY = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SCAN   = 2'd2
    } hp_state_e;

    localparam logic [7:0] CMD_SEARCH = 8'd0;
    localparam logic [7:0] CMD_REPEVT = 8'd1;
    localparam logic [7:0] CMD_REPSTS = 8'd2;

    localparam logic [1:0] W_SEL  = 2'd0;
    localparam logic [1:0] W_CTRL = 2'd1;
    localparam logic [1:0] W_DATA = 2'd2;
    localparam logic [1:0] W_GPE  = 2'd3;
endpackage

// File: rtl/hp_slot_flags.sv
module hp_slot_flags #(
    parameter int NSLOT = 8,
    parameter int SW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             plug_valid,
    input  logic [SW-1:0]    plug_slot,
    input  logic             unplug_valid,
    input  logic [SW-1:0]    unplug_slot,
    input  logic             ack_ins,
    input  logic             ack_rem,
    input  logic [SW-1:0]    ack_slot,
    input  logic             done_valid,
    input  logic [SW-1:0]    done_slot,
    output logic [NSLOT-1:0] en_o,
    output logic [NSLOT-1:0] ins_o,
    output logic [NSLOT-1:0] rem_o,
    output logic             new_event
);
    logic [NSLOT-1:0] plug_hit;
    logic [NSLOT-1:0] unplug_hit;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic ack_hit;
        logic done_hit;

        assign plug_hit[i]   = plug_valid && (plug_slot == SW'(i));
        assign unplug_hit[i] = unplug_valid && (unplug_slot == SW'(i)) && en_o[i];
        assign ack_hit       = (ack_slot == SW'(i));
        assign done_hit      = done_valid && (done_slot == SW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_o[i]  <= 1'b0;
                ins_o[i] <= 1'b0;
                rem_o[i] <= 1'b0;
            end else begin
                if (plug_hit[i])
                    en_o[i] <= 1'b1;
                else if (done_hit)
                    en_o[i] <= 1'b0;

                if (plug_hit[i])
                    ins_o[i] <= 1'b1;
                else if (ack_ins && ack_hit)
                    ins_o[i] <= 1'b0;

                if (unplug_hit[i])
                    rem_o[i] <= 1'b1;
                else if ((ack_rem && ack_hit) || done_hit)
                    rem_o[i] <= 1'b0;
            end
        end
    end

    assign new_event = (|plug_hit) || (|unplug_hit);
endmodule

// File: rtl/hp_gpe.sv
module hp_gpe (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       event_in,
    input  logic       wr_sts,
    input  logic       wr_en,
    input  logic [7:0] sts_byte,
    input  logic [7:0] en_byte,
    output logic       sts_q,
    output logic       en_q,
    output logic       irq
);
    localparam int GPE_BIT = 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            if (event_in)
                sts_q <= 1'b1;
            else if (wr_sts && sts_byte[GPE_BIT])
                sts_q <= 1'b0;
            if (wr_en)
                en_q <= en_byte[GPE_BIT];
        end
    end

    assign irq = sts_q & en_q;
endmodule

// File: rtl/hotplug_regs.sv
module hotplug_regs
    import hp_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [3:0]    acc_addr,
    input  logic [3:0]    acc_be,
    input  logic [31:0]   acc_wdata,
    output logic [31:0]   acc_rdata,
    input  logic          plug_valid,
    input  logic [SW-1:0] plug_slot,
    input  logic          unplug_valid,
    input  logic [SW-1:0] unplug_slot,
    input  logic          eject_done_valid,
    input  logic [SW-1:0] eject_done_slot,
    output logic          eject_pulse,
    output logic [SW-1:0] eject_slot,
    output logic [31:0]   report_event,
    output logic [31:0]   report_status,
    output logic          report_notify,
    output logic          irq
);
    localparam int          STEPW    = SW + 1;
    localparam logic [SW-1:0] LAST_SLOT = SW'(NSLOT - 1);

    hp_state_e          state_q, state_d;
    logic [31:0]        sel_q;
    logic [7:0]         cmd_q;
    logic [SW-1:0]      cursor_q;
    logic [STEPW-1:0]   steps_q;
    logic [NSLOT-1:0]   en_v, ins_v, rem_v;
    logic               new_event, gpe_sts, gpe_en;

    logic        wr;
    logic [1:0]  word;
    logic        full;
    logic        sel_ok;
    logic [SW-1:0] sel_idx;
    logic        legacy_switch, sel_wr, ctrl_wr, cmd_wr, scan_start, data_wr;
    logic        hit, scan_last;
    logic [7:0]  status_byte;

    assign wr      = acc_valid && acc_write;
    assign word    = acc_addr[3:2];
    assign full    = (acc_be == 4'hF);
    assign sel_ok  = (sel_q < 32'(NSLOT));
    assign sel_idx = sel_q[SW-1:0];

    assign legacy_switch = (state_q == ST_LEGACY) && wr && word == W_SEL && full && acc_wdata == 32'd0;
    assign sel_wr        = (state_q == ST_IDLE) && wr && word == W_SEL && full;
    assign ctrl_wr       = (state_q == ST_IDLE) && wr && word == W_CTRL && acc_be[0] && sel_ok;
    assign cmd_wr        = (state_q == ST_IDLE) && wr && word == W_CTRL && acc_be[1];
    assign scan_start    = cmd_wr && acc_wdata[15:8] == CMD_SEARCH;
    assign data_wr       = (state_q == ST_IDLE) && wr && word == W_DATA && full;

    hp_slot_flags #(.NSLOT(NSLOT), .SW(SW)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .plug_valid   (plug_valid),
        .plug_slot    (plug_slot),
        .unplug_valid (unplug_valid),
        .unplug_slot  (unplug_slot),
        .ack_ins      (ctrl_wr && acc_wdata[1]),
        .ack_rem      (ctrl_wr && acc_wdata[2]),
        .ack_slot     (sel_idx),
        .done_valid   (eject_done_valid),
        .done_slot    (eject_done_slot),
        .en_o         (en_v),
        .ins_o        (ins_v),
        .rem_o        (rem_v),
        .new_event    (new_event)
    );

    hp_gpe u_gpe (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_in (new_event),
        .wr_sts   (wr && word == W_GPE && acc_be[0]),
        .wr_en    (wr && word == W_GPE && acc_be[1]),
        .sts_byte (acc_wdata[7:0]),
        .en_byte  (acc_wdata[15:8]),
        .sts_q    (gpe_sts),
        .en_q     (gpe_en),
        .irq      (irq)
    );

    // slot under the scan cursor and selected-slot status
    always_comb begin
        hit         = 1'b0;
        status_byte = 8'd0;
        for (int i = 0; i < NSLOT; i++) begin
            if (cursor_q == SW'(i))
                hit = ins_v[i] | rem_v[i];
            if (sel_ok && sel_idx == SW'(i))
                status_byte = {5'd0, rem_v[i], ins_v[i], en_v[i]};
        end
    end

    assign scan_last = (steps_q == STEPW'(NSLOT - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LEGACY: if (legacy_switch) state_d = ST_IDLE;
            ST_IDLE:   if (scan_start) state_d = ST_SCAN;
            ST_SCAN:   if (hit || scan_last) state_d = ST_IDLE;
            default:   state_d = ST_LEGACY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LEGACY;
        else        state_q <= state_d;
    end

    // registered outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q         <= 32'd0;
            cmd_q         <= CMD_SEARCH;
            cursor_q      <= '0;
            steps_q       <= '0;
            eject_pulse   <= 1'b0;
            eject_slot    <= '0;
            report_event  <= 32'd0;
            report_status <= 32'd0;
            report_notify <= 1'b0;
        end else begin
            eject_pulse   <= ctrl_wr && acc_wdata[3];
            report_notify <= 1'b0;
            if (ctrl_wr && acc_wdata[3])
                eject_slot <= sel_idx;
            if (sel_wr)
                sel_q <= acc_wdata;
            if (cmd_wr)
                cmd_q <= acc_wdata[15:8];
            if (scan_start) begin
                steps_q  <= '0;
                cursor_q <= (!sel_ok || sel_idx == LAST_SLOT) ? '0 : sel_idx + 1'b1;
            end
            if (state_q == ST_SCAN) begin
                if (hit)
                    sel_q <= 32'(cursor_q);
                cursor_q <= (cursor_q == LAST_SLOT) ? '0 : cursor_q + 1'b1;
                steps_q  <= steps_q + 1'b1;
            end
            if (data_wr && cmd_q == CMD_REPEVT)
                report_event <= acc_wdata;
            if (data_wr && cmd_q == CMD_REPSTS) begin
                report_status <= acc_wdata;
                report_notify <= 1'b1;
            end
        end
    end

    // read mux
    always_comb begin
        acc_rdata = 32'd0;
        if (word == W_GPE)
            acc_rdata = {16'd0, 5'd0, gpe_en, 2'd0, 5'd0, gpe_sts, 2'd0};
        else if (state_q == ST_LEGACY) begin
            if (word == W_SEL)
                acc_rdata = 32'(en_v);
        end else begin
            unique case (word)
                W_CTRL:  acc_rdata = {24'd0, status_byte};
                W_DATA:  acc_rdata = (cmd_q == CMD_SEARCH) ? sel_q : 32'hFFFF_FFFF;
                default: acc_rdata = 32'd0;
            endcase
        end
    end
endmodule

// File: rtl/hotplug_regs_chk.sv
module hotplug_regs_chk
    import hp_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int SW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [3:0]    acc_addr,
    input logic [3:0]    acc_be,
    input logic [31:0]   acc_wdata,
    input logic          eject_pulse,
    input logic [SW-1:0] eject_slot,
    input logic          report_notify,
    input logic          irq,
    input hp_state_e     state_q
);
    logic wr;
    assign wr = acc_valid && acc_write;

    AST_LEGACY_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_LEGACY |=> state_q != ST_LEGACY); // R2

    AST_EJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        eject_pulse |-> $past(wr && acc_addr[3:2] == W_CTRL && acc_be[0] && acc_wdata[3])); // R6

    AST_EJECT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        eject_pulse |-> (int'(eject_slot) < NSLOT)); // R7

    AST_NOTIFY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        report_notify |-> $past(wr && acc_addr[3:2] == W_DATA && acc_be == 4'hF)); // R9

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr && acc_addr[3:2] == W_GPE)) |=> irq); // R11
endmodule

bind hotplug_regs hotplug_regs_chk #(.NSLOT(NSLOT), .SW(SW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_addr      (acc_addr),
    .acc_be        (acc_be),
    .acc_wdata     (acc_wdata),
    .eject_pulse   (eject_pulse),
    .eject_slot    (eject_slot),
    .report_notify (report_notify),
    .irq           (irq),
    .state_q       (state_q)
);

// File: tb/sim_hotplug_regs.sv
`timescale 1ns/1ps
module sim_hotplug_regs;
    localparam int NSLOT = 6;
    localparam int SW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]    acc_addr = '0, acc_be = '0;
    logic [31:0]   acc_wdata = '0, acc_rdata;
    logic          plug_valid = 1'b0, unplug_valid = 1'b0, eject_done_valid = 1'b0;
    logic [SW-1:0] plug_slot = '0, unplug_slot = '0, eject_done_slot = '0;
    logic          eject_pulse, report_notify, irq;
    logic [SW-1:0] eject_slot;
    logic [31:0]   report_event, report_status;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // bench model
    bit m_en [NSLOT];
    bit m_ins[NSLOT];
    bit m_rem[NSLOT];
    int m_sel = 0;
    bit m_sts = 0, m_gen = 0;

    always #4 clk = ~clk;

    hotplug_regs #(.NSLOT(NSLOT)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .plug_valid(plug_valid), .plug_slot(plug_slot),
        .unplug_valid(unplug_valid), .unplug_slot(unplug_slot),
        .eject_done_valid(eject_done_valid), .eject_done_slot(eject_done_slot),
        .eject_pulse(eject_pulse), .eject_slot(eject_slot),
        .report_event(report_event), .report_status(report_status),
        .report_notify(report_notify), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = a; acc_be = be; acc_wdata = d;
        @(negedge clk);
        acc_valid = 0; acc_write = 0; acc_be = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_addr = a;
        #1 d = acc_rdata;
    endtask

    task automatic plug(input int s);
        @(negedge clk);
        plug_valid = 1; plug_slot = SW'(s);
        @(negedge clk);
        plug_valid = 0;
        m_en[s] = 1; m_ins[s] = 1; m_sts = 1;
    endtask

    task automatic unplug(input int s);
        @(negedge clk);
        unplug_valid = 1; unplug_slot = SW'(s);
        @(negedge clk);
        unplug_valid = 0;
        if (m_en[s]) begin m_rem[s] = 1; m_sts = 1; end
    endtask

    task automatic eject_done(input int s);
        @(negedge clk);
        eject_done_valid = 1; eject_done_slot = SW'(s);
        @(negedge clk);
        eject_done_valid = 0;
        m_en[s] = 0; m_rem[s] = 0;
    endtask

    function automatic logic [31:0] exp_status();
        if (m_sel >= NSLOT) return 32'd0;
        return {29'd0, m_rem[m_sel], m_ins[m_sel], m_en[m_sel]};
    endfunction

    function automatic logic [31:0] exp_bitmap();
        logic [31:0] b = 0;
        for (int i = 0; i < NSLOT; i++) b[i] = m_en[i];
        return b;
    endfunction

    task automatic set_sel(input int s);
        wr(4'h0, 4'hF, 32'(s));
        m_sel = s;
    endtask

    task automatic ctrl(input logic [7:0] v);
        wr(4'h4, 4'h1, {24'd0, v});
        if (m_sel < NSLOT) begin
            if (v[1]) m_ins[m_sel] = 0;
            if (v[2]) m_rem[m_sel] = 0;
        end
    endtask

    task automatic search();
        wr(4'h4, 4'h2, 32'h0000_0000);
        repeat (NSLOT + 2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NSLOT; i++) begin m_en[i] = 0; m_ins[i] = 0; m_rem[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 0);
        rd(4'h0, d); chk("R1 bitmap", d, 0);
        rd(4'h4, d); chk("R1 word1", d, 0);
        rd(4'hC, d); chk("R1 gpe", d, 0);

        // R3 hot-add visible in legacy bitmap, R11 status set
        plug(2); plug(4);
        rd(4'h0, d); chk("R3 bitmap", d, exp_bitmap());
        rd(4'hC, d); chk("R11 gpe sts", d, 32'h4);
        chk("R11 irq masked", {31'd0, irq}, 0);

        // R1 non-zero write ignored in legacy
        wr(4'h0, 4'hF, 32'h1);
        rd(4'h0, d); chk("R1 legacy stays", d, exp_bitmap());
        rd(4'h8, d); chk("R1 word2 legacy", d, 0);

        // R2 switch
        wr(4'h0, 4'hF, 32'h0);
        rd(4'h0, d); chk("R2 word0 new mode", d, 0);
        set_sel(2);
        rd(4'h4, d); chk("R3 status slot2", d, exp_status());

        // R11 enable / W1C
        wr(4'hC, 4'h2, 32'h0000_0400); m_gen = 1;
        @(negedge clk); chk("R11 irq on", {31'd0, irq}, 1);
        wr(4'hC, 4'h1, 32'h4); m_sts = 0;
        @(negedge clk); chk("R11 irq cleared", {31'd0, irq}, 0);

        // R2 zero write in new mode only loads selector
        set_sel(0);
        rd(4'h0, d); chk("R2 no return to legacy", d, 0);
        rd(4'h8, d); chk("R2 selector 0", d, 0);

        // R5 acknowledge
        set_sel(2); ctrl(8'h02);
        rd(4'h4, d); chk("R5 ins cleared", d, 32'h1);
        set_sel(4); ctrl(8'hF1);
        rd(4'h4, d); chk("R5 reserved bits", d, 32'h3);

        // R8 search
        set_sel(2); search();
        rd(4'h8, d); chk("R8 found slot4", d, 4); m_sel = 4;
        ctrl(8'h02); search();
        rd(4'h8, d); chk("R8 none unchanged", d, 4);
        plug(1); search();
        rd(4'h8, d); chk("R8 wrap", d, 1); m_sel = 1;
        set_sel(9); plug(5); search();
        rd(4'h8, d); chk("R8 from out of range", d, 1); m_sel = 1;
        ctrl(8'h02); set_sel(5); ctrl(8'h02);

        // R7 out-of-range selector
        set_sel(6);
        rd(4'h4, d); chk("R7 status zero", d, 0);
        wr(4'h4, 4'h1, 32'h0E);
        chk("R7 no eject", {31'd0, eject_pulse}, 0);
        set_sel(4);
        rd(4'h4, d); chk("R7 flags untouched", d, exp_status());

        // R4 unplug
        unplug(2); set_sel(2);
        rd(4'h4, d); chk("R4 remove set", d, 32'h5);
        unplug(3); set_sel(3);
        rd(4'h4, d); chk("R4 disabled ignored", d, 0);

        // R6 eject
        set_sel(2);
        wr(4'h4, 4'h1, 32'h08);
        chk("R6 eject pulse", {31'd0, eject_pulse}, 1);
        chk("R6 eject slot", 32'(eject_slot), 2);
        @(negedge clk); chk("R6 pulse one cycle", {31'd0, eject_pulse}, 0);
        eject_done(2);
        rd(4'h4, d); chk("R6 done clears", d, exp_status());

        // R9 report words
        wr(4'h4, 4'h2, 32'h0000_0100);
        wr(4'h8, 4'hF, 32'hA5A5_0001);
        chk("R9 event word", report_event, 32'hA5A5_0001);
        chk("R9 no notify cmd1", {31'd0, report_notify}, 0);
        rd(4'h8, d); chk("R10 read cmd1", d, 32'hFFFF_FFFF);
        wr(4'h4, 4'h2, 32'h0000_0200);
        wr(4'h8, 4'hF, 32'h0000_1234);
        chk("R9 status word", report_status, 32'h1234);
        chk("R9 notify", {31'd0, report_notify}, 1);
        @(negedge clk); chk("R9 notify one cycle", {31'd0, report_notify}, 0);

        // R10 reserved command
        wr(4'h4, 4'h2, 32'h0000_0700);
        rd(4'h8, d); chk("R10 read cmd7", d, 32'hFFFF_FFFF);
        wr(4'h8, 4'hF, 32'hDEAD_BEEF);
        chk("R10 event kept", report_event, 32'hA5A5_0001);
        chk("R10 status kept", report_status, 32'h1234);

        // random phase: R3 R4 R5 R7 R11 against the model
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 4);
            int s  = $urandom_range(0, NSLOT - 1);
            case (op)
                0: plug(s);
                1: unplug(s);
                2: set_sel($urandom_range(0, 7));
                3: ctrl(8'($urandom) & 8'hF7);
                default: begin
                    wr(4'hC, 4'h1, 32'h4); m_sts = 0;
                end
            endcase
            rd(4'h4, d); chk("R3 R4 R5 R7 random status", d, exp_status());
            chk("R11 random irq", {31'd0, irq}, {31'd0, m_sts & m_gen});
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule